// File: doc/BRIEF.md
# Transmit Character FIFO with Status Flags

This block buffers 10-bit line characters (eight data bits plus two control bits) between a host write port and a line encoder. It holds up to 256 characters. The encoder always sees the oldest character on a look-ahead output and removes it with a read strobe. Two status flags go back to the host. A half-full flag reports when the queue holds half its depth or more. An empty flag reports when nothing is waiting for the encoder. The active level of the empty flag is chosen by an input.

A bypass input turns the queue into a straight wire from the write port to the encoder, and the stored contents are left untouched. A clear request empties the queue, but only once it has been held for seven consecutive clock samples. The clear then runs for four cycles, and during that time the flags report the queue as full and not empty. While the self-test input is high, the empty flag stops following the queue. It instead gives a single-cycle pulse at the end of every test sequence, whatever the bypass input says.

The block uses one clock domain with a synchronous active-high reset.

Top module: `txchar_fifo`

## Requirements
- R1: Characters leave in the order they were written. `rd_char` shows the oldest stored character, `rd_valid` is high whenever the queue is not empty, and `rd_en` with `rd_valid` high removes that character at the clock edge.
- R2: Outside a clear and outside bypass, `half_flag` is 1 exactly when the occupancy is 128 or more (DEPTH/2).
- R3: Outside self-test, clear and bypass, the empty flag is active exactly when the occupancy is 0.
- R4: A write while the queue holds 256 characters is dropped. A read while the queue is empty changes nothing.
- R5: `empty_pol` = 1 makes the empty flag active-high. `empty_pol` = 0 makes it active-low.
- R6: A clear starts at the edge where `clr_req` has been sampled high for the seventh consecutive time. A run of six or fewer high samples has no effect. A request held high after launch does not start a second clear until it has been sampled low.
- R7: A clear lasts 4 cycles after its launch edge. During those cycles `half_flag` = 1, the empty flag is inactive, `rd_valid` = 0 and writes are dropped. After the clear the queue is empty.
- R8: With `bypass` = 1, `rd_char` equals `wr_char` and `rd_valid` equals `wr_en` in the same cycle, `half_flag` = 0 and the empty flag is active. Stored characters are kept and reappear when bypass ends.
- R9: With `selftest_en` = 1 the empty flag ignores bypass and the queue state. It is active for exactly one cycle, the SEQ_LEN-th cycle counted from the edge that first samples `selftest_en` high, and then every SEQ_LEN cycles after that (SEQ_LEN = 511).
- R10: A write and a read in the same cycle, with the queue neither full nor empty, both take effect and leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | 1 = pass characters straight through |
| empty_pol | input | 1 | Active level of the empty flag |
| selftest_en | input | 1 | 1 = empty flag becomes the test-loop pulse |
| clr_req | input | 1 | Queue clear request, qualified over seven samples |
| wr_en | input | 1 | Write strobe from the host |
| wr_char | input | 10 | Character to write, {control[1:0], data[7:0]} |
| rd_en | input | 1 | Read strobe from the encoder |
| rd_char | output | 10 | Oldest character (or `wr_char` in bypass) |
| rd_valid | output | 1 | `rd_char` holds a character |
| half_flag | output | 1 | Half-full status |
| empty_flag | output | 1 | Empty status or self-test pulse, polarity set by `empty_pol` |

## Verification
Read and write can land in the same cycle. The bench provokes this by strobing both while the occupancy sits one below the half mark, and again while it sits exactly on the half mark. The half flag must not move in either case, and a queue model in the bench then checks that the drained data is in order. The clear launch can also coincide with a held write. Writes presented during the four clear cycles are judged by `rd_valid` staying low and by the queue being empty afterwards.

// File: rtl/txchar_pkg.sv
package txchar_pkg;

    localparam int CHAR_W    = 10;
    localparam int CLR_QUAL  = 7;
    localparam int CLR_LEN   = 4;

    typedef struct packed {
        logic [1:0] ctl;
        logic [7:0] dat;
    } txchar_t;

    typedef enum logic [1:0] {
        EMODE_LEVEL      = 2'd0,
        EMODE_FORCED_OFF = 2'd1,
        EMODE_BYPASS_ON  = 2'd2,
        EMODE_SELFTEST   = 2'd3
    } emode_e;

    function automatic logic apply_pol(input logic active, input logic pol);
        return pol ? active : ~active;
    endfunction

endpackage

// File: rtl/txchar_store.sv
module txchar_store
    import txchar_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int PW   = $clog2(DEPTH),
    localparam int OCW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           push_req,
    input  txchar_t        push_char,
    input  logic           pop_req,
    output txchar_t        head_char,
    output logic [OCW-1:0] occ,
    output logic           has_data,
    output logic           full
);

    txchar_t          mem [DEPTH];
    logic [PW-1:0]    wptr;
    logic [PW-1:0]    rptr;
    logic             push_ok;
    logic             pop_ok;

    assign has_data  = (occ != '0);
    assign full      = (occ == OCW'(DEPTH));
    assign push_ok   = push_req && !full && !clr;
    assign pop_ok    = pop_req && has_data && !clr;
    assign head_char = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= push_char;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (push_ok) begin
                wptr <= wptr + 1'b1;
            end
            if (pop_ok) begin
                rptr <= rptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= OCW'(DEPTH)) else $error("occupancy above depth"); // R4

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (full && push_req && !pop_req && !clr) |=> $stable(occ)) else $error("write into full queue"); // R4

    AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (rst)
        (!has_data && pop_req && !push_req && !clr) |=> ((occ == '0) && $stable(rptr))) else $error("read from empty queue moved state"); // R4

    AST_BOTH_KEEP_OCC: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && has_data && !full && !clr) |=> $stable(occ)) else $error("simultaneous access changed occupancy"); // R10

endmodule

// File: rtl/txchar_clrseq.sv
module txchar_clrseq
    import txchar_pkg::*;
#(
    parameter int QUAL  = CLR_QUAL,
    parameter int LEN   = CLR_LEN,
    localparam int QW   = $clog2(QUAL + 1),
    localparam int RW   = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic busy
);

    logic [QW-1:0] qcnt;
    logic [RW-1:0] rem;
    logic          launch;

    assign busy   = (rem != '0);
    assign launch = req && (qcnt == QW'(QUAL - 1)) && !busy;

    always_ff @(posedge clk) begin
        if (rst || !req) begin
            qcnt <= '0;
        end else if (qcnt != QW'(QUAL)) begin
            qcnt <= qcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (launch) begin
            rem <= RW'(LEN);
        end else if (busy) begin
            rem <= rem - 1'b1;
        end
    end

    AST_CLR_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(qcnt) == QW'(QUAL - 1))) else $error("clear launched without qualification"); // R6

    AST_CLR_NO_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
        (req && (qcnt == QW'(QUAL)) && !busy) |=> !busy) else $error("held request relaunched clear"); // R6

endmodule

// File: rtl/txchar_loop.sv
module txchar_loop #(
    parameter int SEQ_LEN = 511,
    localparam int LCW    = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic pulse
);

    logic [LCW-1:0] lcnt;
    logic           at_end;

    assign at_end = (lcnt == LCW'(SEQ_LEN - 1));
    assign pulse  = en && at_end;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            lcnt <= '0;
        end else if (at_end) begin
            lcnt <= '0;
        end else begin
            lcnt <= lcnt + 1'b1;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse) else $error("self-test pulse longer than one cycle"); // R9

endmodule

// File: rtl/txchar_flags.sv
module txchar_flags
    import txchar_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int OCW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OCW-1:0] occ,
    input  logic           busy,
    input  logic           bypass,
    input  logic           st_en,
    input  logic           st_pulse,
    input  logic           pol,
    output logic           half_o,
    output logic           empty_o
);

    emode_e mode;
    logic   empty_act;

    always_comb begin
        if (st_en) begin
            mode = EMODE_SELFTEST;
        end else if (busy) begin
            mode = EMODE_FORCED_OFF;
        end else if (bypass) begin
            mode = EMODE_BYPASS_ON;
        end else begin
            mode = EMODE_LEVEL;
        end
    end

    always_comb begin
        case (mode)
            EMODE_SELFTEST:   empty_act = st_pulse;
            EMODE_FORCED_OFF: empty_act = 1'b0;
            EMODE_BYPASS_ON:  empty_act = 1'b1;
            default:          empty_act = (occ == '0);
        endcase
    end

    always_comb begin
        if (busy) begin
            half_o = 1'b1;
        end else if (bypass) begin
            half_o = 1'b0;
        end else begin
            half_o = (occ >= OCW'(DEPTH / 2));
        end
    end

    assign empty_o = apply_pol(empty_act, pol);

    AST_BYPASS_HALF_LOW: assert property (@(posedge clk) disable iff (rst)
        (bypass && !busy) |-> !half_o) else $error("half flag set in bypass"); // R8

    AST_SELFTEST_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st_en && !st_pulse) |-> (empty_o == !pol)) else $error("empty flag active between pulses"); // R9

endmodule

// File: rtl/txchar_fifo.sv
module txchar_fifo
    import txchar_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int SEQ_LEN = 511,
    localparam int OCW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic              empty_pol,
    input  logic              selftest_en,
    input  logic              clr_req,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              rd_en,
    output logic [CHAR_W-1:0] rd_char,
    output logic              rd_valid,
    output logic              half_flag,
    output logic              empty_flag
);

    txchar_t        in_char;
    txchar_t        head_char;
    logic [OCW-1:0] occ;
    logic           has_data;
    logic           full;
    logic           busy;
    logic           st_pulse;
    logic           push_req;
    logic           pop_req;

    assign in_char  = txchar_t'(wr_char);
    assign push_req = wr_en && !bypass;
    assign pop_req  = rd_en && !bypass;

    txchar_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (busy),
        .push_req  (push_req),
        .push_char (in_char),
        .pop_req   (pop_req),
        .head_char (head_char),
        .occ       (occ),
        .has_data  (has_data),
        .full      (full)
    );

    txchar_clrseq u_clr (
        .clk  (clk),
        .rst  (rst),
        .req  (clr_req),
        .busy (busy)
    );

    txchar_loop #(.SEQ_LEN(SEQ_LEN)) u_loop (
        .clk   (clk),
        .rst   (rst),
        .en    (selftest_en),
        .pulse (st_pulse)
    );

    txchar_flags #(.DEPTH(DEPTH)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .occ      (occ),
        .busy     (busy),
        .bypass   (bypass),
        .st_en    (selftest_en),
        .st_pulse (st_pulse),
        .pol      (empty_pol),
        .half_o   (half_flag),
        .empty_o  (empty_flag)
    );

    always_comb begin
        if (bypass) begin
            rd_char  = wr_char;
            rd_valid = wr_en;
        end else begin
            rd_char  = head_char;
            rd_valid = has_data && !busy;
        end
    end

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        busy |=> (occ == '0)) else $error("clear left characters"); // R7

    AST_CLR_HIDES_DATA: assert property (@(posedge clk) disable iff (rst)
        (busy && !bypass) |-> (!rd_valid && half_flag)) else $error("queue visible during clear"); // R7

endmodule

// File: tb/txchar_fifo_test.sv
module txchar_fifo_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bypass = 1'b0;
    logic       empty_pol = 1'b1;
    logic       selftest_en = 1'b0;
    logic       clr_req = 1'b0;
    logic       wr_en = 1'b0;
    logic [9:0] wr_char = '0;
    logic       rd_en = 1'b0;
    logic [9:0] rd_char;
    logic       rd_valid;
    logic       half_flag;
    logic       empty_flag;

    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic [9:0] model_q[$];

    always #10 clk = ~clk;

    txchar_fifo uut (
        .clk(clk), .rst(rst), .bypass(bypass), .empty_pol(empty_pol),
        .selftest_en(selftest_en), .clr_req(clr_req), .wr_en(wr_en),
        .wr_char(wr_char), .rd_en(rd_en), .rd_char(rd_char),
        .rd_valid(rd_valid), .half_flag(half_flag), .empty_flag(empty_flag)
    );

    function automatic logic [9:0] pat(input int i);
        return {2'(i[1:0] ^ i[3:2]), 8'(i[7:0] ^ 8'h5A)};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_level();
        int occ = model_q.size();
        check("R2 half", 32'(half_flag), 32'(occ >= 128));
        check("R3 empty", 32'(empty_flag), 32'(empty_pol ? (occ == 0) : (occ != 0)));
        check("R1 valid", 32'(rd_valid), 32'(occ != 0));
        if (occ != 0) check("R1 head", 32'(rd_char), 32'(model_q[0]));
    endtask

    task automatic push(input logic [9:0] c);
        wr_en = 1'b1; wr_char = c; tick(); wr_en = 1'b0;
        model_q.push_back(c);
    endtask

    task automatic pop();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        void'(model_q.pop_front());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick(); rst = 1'b0; tick();
        // Reset state: R3 empty active, R2 half low
        check_level();

        // R1 R2 R3: fill sweep
        for (int i = 0; i < 256; i++) begin
            push(pat(i));
            check_level();
        end
        // R4: write into full queue dropped
        wr_en = 1'b1; wr_char = 10'h3FF; tick(); wr_en = 1'b0;
        check_level();

        // R8: bypass at full
        bypass = 1'b1; #1;
        check("R8 half", 32'(half_flag), 32'd0);
        check("R8 empty", 32'(empty_flag), 32'd1);
        check("R8 valid idle", 32'(rd_valid), 32'd0);
        wr_en = 1'b1; wr_char = 10'h155; #1;
        check("R8 pass valid", 32'(rd_valid), 32'd1);
        check("R8 pass char", 32'(rd_char), 32'h155);
        rd_en = 1'b1; tick(); wr_en = 1'b0; rd_en = 1'b0;
        bypass = 1'b0; #1;
        check("R8 contents kept", 32'(rd_char), 32'(pat(0)));
        check_level();

        // R1 drain in order
        for (int i = 0; i < 256; i++) begin
            pop();
            check_level();
        end
        // R4: read from empty
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        check_level();
        push(10'h2A5);
        check_level();
        pop();
        check_level();

        // R10: simultaneous access at 127 and at 128
        for (int i = 0; i < 127; i++) push(pat(i + 300));
        check_level();
        for (int i = 0; i < 4; i++) begin
            wr_en = 1'b1; wr_char = pat(i + 600); rd_en = 1'b1; tick();
            wr_en = 1'b0; rd_en = 1'b0;
            model_q.push_back(pat(i + 600)); void'(model_q.pop_front());
            check("R10 half stays low", 32'(half_flag), 32'd0);
            check_level();
        end
        push(pat(700));
        check_level();
        for (int i = 0; i < 4; i++) begin
            wr_en = 1'b1; wr_char = pat(i + 800); rd_en = 1'b1; tick();
            wr_en = 1'b0; rd_en = 1'b0;
            model_q.push_back(pat(i + 800)); void'(model_q.pop_front());
            check("R10 half stays high", 32'(half_flag), 32'd1);
            check_level();
        end

        // R5: active-low polarity
        empty_pol = 1'b0; #1;
        check("R5 low nonempty", 32'(empty_flag), 32'd1);
        while (model_q.size() != 0) begin
            pop();
            check_level();
        end
        check("R5 low empty", 32'(empty_flag), 32'd0);
        empty_pol = 1'b1; #1;

        // R6: six samples do nothing
        for (int i = 0; i < 10; i++) push(pat(i + 900));
        clr_req = 1'b1;
        for (int k = 1; k <= 6; k++) tick();
        clr_req = 1'b0; tick();
        check("R6 short request ignored", 32'(rd_valid), 32'd1);
        check_level();

        // R6 R7: qualified clear
        clr_req = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            tick();
            check("R6 before launch", 32'(half_flag), 32'd0);
        end
        tick();
        model_q.delete();
        check("R7 half forced", 32'(half_flag), 32'd1);
        check("R7 empty inactive", 32'(empty_flag), 32'd0);
        check("R7 valid low", 32'(rd_valid), 32'd0);
        wr_en = 1'b1; wr_char = 10'h0F0;
        for (int k = 8; k <= 10; k++) begin
            tick();
            check("R7 half forced", 32'(half_flag), 32'd1);
            check("R7 empty inactive", 32'(empty_flag), 32'd0);
            check("R7 valid low", 32'(rd_valid), 32'd0);
        end
        wr_en = 1'b0;
        tick();
        check("R7 cleared empty", 32'(empty_flag), 32'd1);
        check_level();
        // R6: held request must not relaunch
        push(10'h1C3);
        for (int k = 0; k < 12; k++) tick();
        check("R6 no relaunch", 32'(rd_valid), 32'd1);
        check_level();
        clr_req = 1'b0;
        pop();
        check_level();

        // R9: self-test pulse, bypass ignored
        bypass = 1'b1; selftest_en = 1'b1; #1;
        check("R9 start quiet", 32'(empty_flag), 32'd0);
        for (int k = 1; k <= 1100; k++) begin
            tick();
            check("R9 loop pulse", 32'(empty_flag), 32'((k % 511) == 510));
        end
        selftest_en = 1'b0; bypass = 1'b0; #1;
        check_level();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule